// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit timer channel for a larger timer unit. It counts up or down on the system clock, through a clock enable from a power-of-two prescaler. It can run across the full 16-bit range or wrap at a programmable interval. Three match comparators watch the count. Six sticky status flags, gated by an enable mask, drive a single level-sensitive interrupt line.

Configuration arrives on two write strobes. A clock-control write loads the prescaler settings. A counter-control write loads the halt, mode, direction and match-enable bits, and can also zero the count. The interval, the three match values and the interrupt mask are plain inputs that the surrounding register file holds steady. A one-cycle clear strobe empties the status flags. Event-timing logic and the bus interface sit outside this block, so the event flag reads back as zero.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count is 0, all status flags are 0 and the interrupt is low. The channel comes out of reset halted and its count stays at 0 until a counter-control write clears the halt bit.
- R2: While counter-control bit 0 (halt) is 1, the count does not change unless a zeroing write arrives.
- R3: With counter-control bit 1 (interval mode) at 0, the counter steps through all 65536 values. Counting up, it wraps from 0xFFFF to 0. Counting down (bit 2 = 1), it wraps from 0 to 0xFFFF. Each wrap sets status bit 4 (overflow) and leaves bit 0 alone.
- R4: With interval mode at 1, the counter steps through the values 0 up to the interval value. Counting up, it wraps from the interval value to 0. Counting down, it reloads the interval value after 0. Each wrap sets status bit 0 and leaves bit 4 alone.
- R5: Clock-control bit 0 enables the prescaler and bits 4:1 hold N. When the prescaler is enabled, the counter steps once every 2^(N+1) clocks. When it is disabled, the counter steps on every clock. A clock-control write, or a zeroing counter write, restarts the prescaler, so the first step comes one full period later.
- R6: With counter-control bit 3 (match enable) at 1, status bit i+1 (i = 0..2) sets in the cycle the count steps onto match value i. A match value above the interval in interval mode never sets its bit.
- R7: With match enable at 0, no match status bit sets.
- R8: Status bits stay set until the clear strobe. A bit whose condition occurs in the same cycle as the clear is kept.
- R9: The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R10: A counter-control write with bit 4 set zeroes the count in the same cycle, and bit 4 is not stored. Status bit 5 (event) always reads 0.
- R11: Between two cycles, the count either holds, moves by one, wraps to 0, or reloads the wrap limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_cfg_wr | input | 1 | Load strobe for the clock control |
| clk_cfg_in | input | 5 | Clock control: bit 0 prescaler enable, bits 4:1 N |
| cnt_cfg_wr | input | 1 | Load strobe for the counter control |
| cnt_cfg_in | input | 5 | Counter control: bit 0 halt, 1 interval mode, 2 down, 3 match enable, 4 zero count |
| interval | input | 16 | Wrap value in interval mode |
| match_vals | input | 48 | Match values, value i in bits 16i+15:16i |
| irq_en | input | 6 | Interrupt enable mask, one bit per status bit |
| status_clr | input | 1 | Clears all status flags |
| count | output | 16 | Current count |
| status | output | 6 | Flags: 0 interval wrap, 3:1 match, 4 overflow, 5 event |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check four properties on every cycle: the count holds while halted, the count moves only in legal steps, flags stay sticky unless cleared, and match flags never rise with match enable off. They also check that the prescaler never lets the count step on two consecutive clocks, and the state just after reset. Only the bench scenarios can show the rest: the actual wrap points and which wrap flag each one raises, the exact prescaler period for each N, which comparator fires at which count, the masking of the interrupt, and that a clear coinciding with a new match keeps the new flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int NMATCH = 3;
    localparam int PSN_W  = 4;
    localparam int ST_W   = NMATCH + 3;

    // counter control, bit 0 = halt ... bit 3 = match enable
    typedef struct packed {
        logic men;
        logic down;
        logic intv;
        logic halt;
    } cnt_cfg_t;

    localparam cnt_cfg_t CNT_CFG_RST = '{men: 1'b0, down: 1'b0, intv: 1'b0, halt: 1'b1};
    localparam int       ZERO_BIT    = 4;

    // all-ones mask of width n+1 bits, i.e. the prescaler terminal count
    function automatic logic [2**PSN_W-1:0] ps_last(input logic [PSN_W-1:0] n);
        return ~({(2**PSN_W){1'b1}} << (32'(n) + 32'd1));
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PSN_W = tmr_pkg::PSN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             en,
    input  logic [PSN_W-1:0] n,
    output logic             tick
);
    localparam int PC_W = 2**PSN_W;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] last;
    logic            term;

    always_comb begin
        last = tmr_pkg::ps_last(n);
        term = (pcnt == last);
        tick = !en || term;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !en || term)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             zero,
    input  logic             down,
    input  logic             intv,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] nxt,
    output logic [CNT_W-1:0] limit,
    output logic             wrap
);
    logic at_edge;

    always_comb begin
        limit   = intv ? interval : {CNT_W{1'b1}};
        at_edge = down ? (count == '0) : (count >= limit);
        nxt     = count;
        if (step) begin
            if (down)
                nxt = at_edge ? limit : count - 1'b1;
            else
                nxt = at_edge ? '0 : count + 1'b1;
        end
        if (zero)
            nxt = '0;
        wrap = step && at_edge && !zero;
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= nxt;
    end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int NMATCH = tmr_pkg::NMATCH
) (
    input  logic                    armed,
    input  logic [CNT_W-1:0]        nxt,
    input  logic [CNT_W-1:0]        limit,
    input  logic [NMATCH*CNT_W-1:0] match_vals,
    output logic [NMATCH-1:0]       hit
);
    for (genvar i = 0; i < NMATCH; i++) begin : g_cmp
        logic [CNT_W-1:0] mv;
        assign mv     = match_vals[i*CNT_W +: CNT_W];
        assign hit[i] = armed && (nxt == mv) && (mv <= limit);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int NMATCH = tmr_pkg::NMATCH,
    parameter int PSN_W  = tmr_pkg::PSN_W,
    localparam int SW    = NMATCH + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_cfg_wr,
    input  logic [PSN_W:0]          clk_cfg_in,
    input  logic                    cnt_cfg_wr,
    input  logic [ZERO_BIT:0]       cnt_cfg_in,
    input  logic [CNT_W-1:0]        interval,
    input  logic [NMATCH*CNT_W-1:0] match_vals,
    input  logic [SW-1:0]           irq_en,
    input  logic                    status_clr,
    output logic [CNT_W-1:0]        count,
    output logic [SW-1:0]           status,
    output logic                    irq
);
    localparam int B_WRAP = 0;
    localparam int B_OVF  = NMATCH + 1;
    localparam int B_EVT  = NMATCH + 2;

    cnt_cfg_t         cnt_q;
    logic [PSN_W:0]   clk_q;
    logic             zero_req;
    logic             tick;
    logic             step;
    logic             wrap;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] limit;
    logic [NMATCH-1:0] hit;
    logic [SW-1:0]    set_v;

    assign zero_req = cnt_cfg_wr && cnt_cfg_in[ZERO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_CFG_RST;
            clk_q <= '0;
        end else begin
            if (cnt_cfg_wr) cnt_q <= cnt_cfg_t'(cnt_cfg_in[ZERO_BIT-1:0]);
            if (clk_cfg_wr) clk_q <= clk_cfg_in;
        end
    end

    tmr_prescale #(.PSN_W(PSN_W)) u_ps (
        .clk     (clk),
        .rst     (rst),
        .restart (clk_cfg_wr || zero_req),
        .en      (clk_q[0]),
        .n       (clk_q[PSN_W:1]),
        .tick    (tick)
    );

    assign step = tick && !cnt_q.halt;

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .zero     (zero_req),
        .down     (cnt_q.down),
        .intv     (cnt_q.intv),
        .interval (interval),
        .count    (count),
        .nxt      (nxt),
        .limit    (limit),
        .wrap     (wrap)
    );

    tmr_match #(.CNT_W(CNT_W), .NMATCH(NMATCH)) u_match (
        .armed      (cnt_q.men && step && !zero_req),
        .nxt        (nxt),
        .limit      (limit),
        .match_vals (match_vals),
        .hit        (hit)
    );

    always_comb begin
        set_v               = '0;
        set_v[B_WRAP]       = wrap && cnt_q.intv;
        set_v[NMATCH:1]     = hit;
        set_v[B_OVF]        = wrap && !cnt_q.intv;
        set_v[B_EVT]        = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status_clr ? '0 : status) | set_v;
    end

    assign irq = |(status & irq_en);
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int NMATCH = tmr_pkg::NMATCH,
    localparam int SW    = NMATCH + 3
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic [SW-1:0]    status,
    input logic             status_clr,
    input logic             halt,
    input logic             men,
    input logic             ps_en,
    input logic             zero_req,
    input logic [CNT_W-1:0] limit
);
    // R1: state just after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && status == '0));

    // R2: halted counter holds
    p_halt_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (halt && !zero_req) |=> $stable(count));

    // R11: legal count movement
    p_legal_step_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(count) || count == $past(count) + 1'b1 ||
                  count == $past(count) - 1'b1 || count == '0 || count == $past(limit)));

    // R8: flags sticky without clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !status_clr |=> ((status & $past(status)) == $past(status)));

    // R7: no match flag while match enable is off
    p_no_match_r7: assert property (@(posedge clk) disable iff (rst)
        !men |=> ((status[NMATCH:1] & ~$past(status[NMATCH:1])) == '0));

    // R5: an enabled prescaler never lets the count step on consecutive clocks
    p_ps_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (ps_en && !zero_req && !$stable(count)) |=> $stable(count));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .NMATCH(NMATCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count      (count),
    .status     (status),
    .status_clr (status_clr),
    .halt       (cnt_q.halt),
    .men        (cnt_q.men),
    .ps_en      (clk_q[0]),
    .zero_req   (zero_req),
    .limit      (limit)
);

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_cfg_wr = 1'b0;
    logic [4:0]  clk_cfg_in = '0;
    logic        cnt_cfg_wr = 1'b0;
    logic [4:0]  cnt_cfg_in = '0;
    logic [15:0] interval = '0;
    logic [47:0] match_vals = '0;
    logic [5:0]  irq_en = '0;
    logic        status_clr = 1'b0;
    logic [15:0] count;
    logic [5:0]  status;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_channel uut (
        .clk(clk), .rst(rst), .clk_cfg_wr(clk_cfg_wr), .clk_cfg_in(clk_cfg_in),
        .cnt_cfg_wr(cnt_cfg_wr), .cnt_cfg_in(cnt_cfg_in), .interval(interval),
        .match_vals(match_vals), .irq_en(irq_en), .status_clr(status_clr),
        .count(count), .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(input logic [4:0] v);
        cnt_cfg_in = v; cnt_cfg_wr = 1'b1;
        @(negedge clk);
        cnt_cfg_wr = 1'b0;
    endtask

    task automatic wr_clk(input logic [4:0] v);
        clk_cfg_in = v; clk_cfg_wr = 1'b1;
        @(negedge clk);
        clk_cfg_wr = 1'b0;
    endtask

    task automatic clear_flags();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        run(3);
        rst = 1'b0;
        irq_en = 6'h3F;
        run(1);
        check("R1 count", 32'(count), 0);
        check("R1 status", 32'(status), 0);
        check("R1 irq", 32'(irq), 0);
        run(5);
        check("R1 halted", 32'(count), 0);
        irq_en = '0;

        // free-running up, halt, zero
        wr_cnt(5'b10000);
        run(10);
        check("R3 up count", 32'(count), 10);
        wr_cnt(5'b00001);
        check("R2 last step", 32'(count), 11);
        run(6);
        check("R2 hold", 32'(count), 11);
        wr_cnt(5'b10000);
        check("R10 zero", 32'(count), 0);
        run(65535);
        check("R3 top", 32'(count), 16'hFFFF);
        check("R3 no flag yet", 32'(status), 0);
        run(1);
        check("R3 wrap", 32'(count), 0);
        check("R3 ovf flag", 32'(status), 6'b010000);
        clear_flags();
        check("R8 cleared", 32'(status), 0);

        // free-running down
        wr_cnt(5'b10100);
        run(1);
        check("R3 down wrap", 32'(count), 16'hFFFF);
        check("R3 down ovf", 32'(status), 6'b010000);
        run(2);
        check("R3 down step", 32'(count), 16'hFFFD);
        clear_flags();

        // interval up
        interval = 16'd5;
        wr_cnt(5'b10010);
        for (int k = 1; k <= 12; k++) begin
            run(1);
            check("R4 up seq", 32'(count), 32'(k % 6));
            if (k == 6) check("R4 wrap flag", 32'(status), 6'b000001);
        end
        clear_flags();

        // interval down
        interval = 16'd4;
        wr_cnt(5'b10110);
        for (int k = 1; k <= 10; k++) begin
            run(1);
            check("R4 down seq", 32'(count), 32'((5 - (k % 5)) % 5));
            if (k == 1) check("R4 down flag", 32'(status), 6'b000001);
        end
        clear_flags();

        // prescaler sweep
        wr_cnt(5'b00001);
        for (int nn = 0; nn < 4; nn++) begin
            int p;
            p = 1 << (nn + 1);
            wr_clk({4'(nn), 1'b1});
            wr_cnt(5'b10000);
            run(p - 1);
            check("R5 before period", 32'(count), 0);
            run(1);
            check("R5 first step", 32'(count), 1);
            run(p);
            check("R5 second step", 32'(count), 2);
        end
        wr_clk(5'b00000);
        wr_cnt(5'b10000);
        run(3);
        check("R5 no prescale", 32'(count), 3);

        // matches
        wr_cnt(5'b00001);
        clear_flags();
        interval = 16'd9;
        match_vals = {16'd12, 16'd7, 16'd3};
        wr_cnt(5'b11010);
        run(2);
        check("R6 none yet", 32'(status), 0);
        run(1);
        check("R6 match0", 32'(status), 6'b000010);
        run(4);
        check("R6 match1", 32'(status), 6'b000110);
        run(3);
        check("R6 wrap", 32'(count), 0);
        check("R6 flags", 32'(status), 6'b000111);
        run(10);
        check("R6 beyond interval", 32'(status), 6'b000111);
        irq_en = 6'b001000;
        run(1);
        check("R9 masked", 32'(irq), 0);
        irq_en = 6'b000100;
        run(1);
        check("R9 enabled", 32'(irq), 1);
        check("R8 at 2", 32'(count), 2);
        irq_en = '0;
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        check("R8 clear vs set", 32'(status), 6'b000010);
        run(4);
        check("R8 sticky", 32'(status), 6'b000110);
        check("R10 event bit", 32'(status[5]), 0);

        // match enable off
        wr_cnt(5'b10010);
        clear_flags();
        run(9);
        check("R7 count", 32'(count), 0);
        check("R7 no match", 32'(status), 6'b000001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule